// File: doc/BRIEF.md
# Read Completion Boundary Splitter

This block sits on the completer side of a split-transaction link. It accepts one memory read request at a time, given as a start address and a byte length. It turns that request into a stream of completion descriptors, one per completion packet that will later return the data. Fetching the data and building packet headers happen elsewhere. Each descriptor carries the address of its first byte, its byte count, the bytes still owed after it, and a flag on the final one.

Split points fall on naturally aligned multiples of the completion boundary, which is selectable as 64 or 128 bytes. A misaligned start therefore gives a short first chunk, and the remainder gives a short last chunk. In split mode every completion covers at most one boundary segment. In packed mode a completion may span several whole segments, but never more than the programmed maximum payload. The boundary, mode and payload limit are sampled when a request is accepted and stay fixed until the request is finished.

Top module: `rcb_splitter`

## Requirements
- R1: During and after reset, `req_ready` is 1, and `cpl_valid` and `req_err` are 0.
- R2: `cfg_bnd_128` picks the boundary size: 0 selects 64 bytes and 1 selects 128 bytes. Every descriptor other than the last ends exactly on an address that is a multiple of that size.
- R3: With `cfg_pack` = 0, each byte count is the smaller of the remaining bytes and the distance from the current address up to the next boundary multiple. A 256-byte read from 0x10028 with a 64-byte boundary gives counts 24, 64, 64, 64 and 40.
- R4: With `cfg_pack` = 1, each byte count is the smaller of the remaining bytes and (payload limit minus the current address modulo the boundary). The payload limit is 128 << `cfg_mps` bytes, with `cfg_mps` from 0 to 3, so no count exceeds it.
- R5: The first descriptor's address is the request address, and each later address is the previous address plus the previous count. `cpl_remain` is the number of bytes still owed after the descriptor. `cpl_last` is 1 exactly when `cpl_remain` is 0.
- R6: A zero-length request is accepted but produces no descriptor. It raises `req_err` for one cycle, in the cycle after acceptance, and `req_ready` stays 1.
- R7: After a non-zero request is accepted, `req_ready` is 0. It returns to 1 in the cycle after the last descriptor is taken (`cpl_valid`, `cpl_ready` and `cpl_last` all 1 at a clock edge).
- R8: While `cpl_valid` is 1 and `cpl_ready` is 0, the descriptor outputs hold their values.
- R9: Changes to `cfg_bnd_128`, `cfg_pack` or `cfg_mps` after a request has been accepted have no effect on that request's descriptors.
- R10: Request lengths of up to 4096 bytes are split completely: a 4096-byte read from an aligned address with a 64-byte boundary in split mode gives 64 descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Splitter idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the first requested byte |
| req_len | input | LEN_W | Requested byte count |
| cfg_bnd_128 | input | 1 | Boundary select: 0 = 64 bytes, 1 = 128 bytes |
| cfg_pack | input | 1 | 0 = one segment per completion, 1 = pack up to the payload limit |
| cfg_mps | input | 2 | Payload limit code, 128 << code bytes |
| cpl_valid | output | 1 | Descriptor available |
| cpl_ready | input | 1 | Consumer takes the descriptor |
| cpl_addr | output | ADDR_W | Address of the descriptor's first byte |
| cpl_len | output | LEN_W | Byte count of this completion |
| cpl_remain | output | LEN_W | Bytes still owed after this completion |
| cpl_last | output | 1 | Final descriptor of the request |
| req_err | output | 1 | One-cycle pulse on a zero-length request |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 13-bit length. This leaves 4096-byte requests within reach. The sweep covers both boundary sizes, both modes and all four payload limits. It uses start offsets inside and across a 128-byte segment, and lengths from one byte to 4096. This reaches the short first and last chunks, exact-fit requests and single-chunk requests. The consumer withholds ready on a fixed rhythm, and the configuration inputs are inverted right after each acceptance. This makes the hold and capture behaviour visible on every request.

// File: rtl/rcbs_pkg.sv
package rcbs_pkg;

    typedef enum logic {
        BND_64  = 1'b0,
        BND_128 = 1'b1
    } bnd_e;

    typedef struct packed {
        bnd_e       bnd;
        logic       pack;
        logic [1:0] mps;
    } cfg_t;

    localparam int SEG_BITS = 7;  // enough for the widest boundary offset

    function automatic int unsigned bnd_bytes(input bnd_e b);
        return (b == BND_128) ? 32'd128 : 32'd64;
    endfunction

    function automatic int unsigned mps_bytes(input logic [1:0] code);
        return 32'd128 << code;
    endfunction

endpackage

// File: rtl/rcbs_limit.sv
module rcbs_limit
    import rcbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  rem,
    output logic [LEN_W-1:0]  chunk
);
    logic [SEG_BITS-1:0] off;
    logic [LEN_W-1:0]    span;
    logic [LEN_W-1:0]    cap;

    always_comb begin
        // offset of the current byte inside its boundary segment
        off  = addr[SEG_BITS-1:0] & SEG_BITS'(bnd_bytes(cfg.bnd) - 32'd1);
        span = cfg.pack ? LEN_W'(mps_bytes(cfg.mps)) : LEN_W'(bnd_bytes(cfg.bnd));
        cap  = span - LEN_W'(off);
        chunk = (rem < cap) ? rem : cap;
    end

endmodule

// File: rtl/rcbs_ctrl.sv
module rcbs_ctrl
    import rcbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  cfg_t              cfg_in,
    output cfg_t              cfg_q,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_rem,
    input  logic [LEN_W-1:0]  chunk,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [LEN_W-1:0]  cpl_remain,
    output logic              cpl_last,
    output logic              req_err
);
    logic              busy;
    logic              accept;
    logic              final_hs;
    logic [ADDR_W-1:0] nxt_addr;

    assign accept     = req_valid && !busy;
    assign req_ready  = !busy;
    assign cpl_valid  = busy;
    assign cpl_last   = (cur_rem == chunk);
    assign cpl_remain = cur_rem - chunk;
    assign nxt_addr   = cur_addr + ADDR_W'(chunk);
    assign final_hs   = busy && cpl_ready && cpl_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            req_err  <= 1'b0;
            cur_addr <= '0;
            cur_rem  <= '0;
            cfg_q    <= '0;
        end else begin
            req_err <= accept && (req_len == '0);
            if (accept && (req_len != '0)) begin
                busy     <= 1'b1;
                cur_addr <= req_addr;
                cur_rem  <= req_len;
                cfg_q    <= cfg_in;
            end else if (busy && cpl_ready) begin
                cur_addr <= nxt_addr;
                cur_rem  <= cpl_remain;
                if (cpl_last) busy <= 1'b0;
            end
        end
    end

    // R2
    boundary_end_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_last |->
            ((nxt_addr[SEG_BITS-1:0] & SEG_BITS'(bnd_bytes(cfg_q.bnd) - 32'd1)) == '0));

    // R4
    payload_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (chunk != '0) && (32'(chunk) <= mps_bytes(cfg_q.mps)));

    // R5
    addr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && cpl_ready && !cpl_last |=>
            cpl_valid && (cur_addr == $past(nxt_addr)) &&
            ((cpl_remain + chunk) == $past(cpl_remain)));

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !cpl_valid && req_ready);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept && (req_len != '0) |=> !req_ready && cpl_valid);

    // R7
    ready_after_final_chk: assert property (@(posedge clk) disable iff (rst)
        final_hs |=> req_ready && !cpl_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_ready |=>
            cpl_valid && $stable(cur_addr) && $stable(chunk) && $stable(cpl_remain));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !final_hs |=> $stable(cfg_q));

endmodule

// File: rtl/rcb_splitter.sv
module rcb_splitter
    import rcbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              cfg_bnd_128,
    input  logic              cfg_pack,
    input  logic [1:0]        cfg_mps,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [ADDR_W-1:0] cpl_addr,
    output logic [LEN_W-1:0]  cpl_len,
    output logic [LEN_W-1:0]  cpl_remain,
    output logic              cpl_last,
    output logic              req_err
);
    cfg_t             cfg_in;
    cfg_t             cfg_q;
    logic [LEN_W-1:0] cur_rem;
    logic [LEN_W-1:0] chunk;

    assign cfg_in  = '{bnd: bnd_e'(cfg_bnd_128), pack: cfg_pack, mps: cfg_mps};
    assign cpl_len = chunk;

    rcbs_limit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_limit (
        .cfg   (cfg_q),
        .addr  (cpl_addr),
        .rem   (cur_rem),
        .chunk (chunk)
    );

    rcbs_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .cfg_in     (cfg_in),
        .cfg_q      (cfg_q),
        .cur_addr   (cpl_addr),
        .cur_rem    (cur_rem),
        .chunk      (chunk),
        .cpl_valid  (cpl_valid),
        .cpl_ready  (cpl_ready),
        .cpl_remain (cpl_remain),
        .cpl_last   (cpl_last),
        .req_err    (req_err)
    );

endmodule

// File: tb/rcb_splitter_test.sv
module rcb_splitter_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              cfg_bnd_128 = 1'b0;
    logic              cfg_pack = 1'b0;
    logic [1:0]        cfg_mps = 2'd0;
    logic              cpl_valid;
    logic              cpl_ready = 1'b0;
    logic [ADDR_W-1:0] cpl_addr;
    logic [LEN_W-1:0]  cpl_len;
    logic [LEN_W-1:0]  cpl_remain;
    logic              cpl_last;
    logic              req_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int got_len[$];

    rcb_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cfg_bnd_128(cfg_bnd_128),
        .cfg_pack(cfg_pack), .cfg_mps(cfg_mps), .cpl_valid(cpl_valid),
        .cpl_ready(cpl_ready), .cpl_addr(cpl_addr), .cpl_len(cpl_len),
        .cpl_remain(cpl_remain), .cpl_last(cpl_last), .req_err(req_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic run_req(input int addr, input int len, input bit bnd, input bit pack, input int mps);
        int    rcb, lim, exp_a, rem, cap, c, guard;
        bit    hs, prev_stall;
        string lreq;
        rcb  = bnd ? 128 : 64;
        lim  = 128 << mps;
        lreq = pack ? "R4" : "R3";
        got_len.delete();
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = ADDR_W'(addr);
        req_len     = LEN_W'(len);
        cfg_bnd_128 = bnd;
        cfg_pack    = pack;
        cfg_mps     = 2'(mps);
        @(negedge clk);
        req_valid   = 1'b0;
        // R9: flip every configuration input once the request is taken
        cfg_bnd_128 = ~bnd;
        cfg_pack    = ~pack;
        cfg_mps     = ~2'(mps);
        if (len == 0) begin
            chk("R6", "err pulse", req_err, 1);
            chk("R6", "no descriptor", cpl_valid, 0);
            @(negedge clk);
            chk("R6", "err ends", req_err, 0);
            chk("R6", "still ready", req_ready, 1);
            chk("R6", "still no descriptor", cpl_valid, 0);
            return;
        end
        chk("R7", "ready low while busy", req_ready, 0);
        exp_a = addr;
        rem   = len;
        guard = 0;
        prev_stall = 1'b0;
        while (rem > 0 && guard < 400) begin
            guard++;
            cap = (pack ? lim : rcb) - (exp_a % rcb);
            c   = (rem < cap) ? rem : cap;
            chk("R5", "valid", cpl_valid, 1);
            chk(lreq, "len", cpl_len, c);
            if (prev_stall) chk("R8", "held addr", cpl_addr, exp_a);
            else            chk("R5", "addr", cpl_addr, exp_a);
            chk("R5", "remain", cpl_remain, rem - c);
            chk("R5", "last", cpl_last, (rem == c));
            if (rem != c) chk("R2", "aligned end", (exp_a + c) % rcb, 0);
            if (pack) chk("R4", "within limit", (c <= lim), 1);
            hs = ((cyc % 3) != 2);
            cyc++;
            cpl_ready = hs;
            @(negedge clk);
            prev_stall = !hs;
            if (hs) begin
                got_len.push_back(c);
                exp_a += c;
                rem   -= c;
            end
        end
        cpl_ready = 1'b0;
        chk("R7", "ready after final", req_ready, 1);
        chk("R7", "idle after final", cpl_valid, 0);
    endtask

    initial begin
        int offs[8] = '{0, 1, 24, 40, 63, 64, 100, 127};
        int lens[10] = '{1, 4, 63, 64, 65, 128, 200, 256, 1000, 4096};
        int want[5] = '{24, 64, 64, 64, 40};
        repeat (3) @(negedge clk);
        // R1
        chk("R1", "ready in reset", req_ready, 1);
        chk("R1", "valid in reset", cpl_valid, 0);
        chk("R1", "err in reset", req_err, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after reset", req_ready, 1);
        chk("R1", "valid after reset", cpl_valid, 0);

        // R3 example with literal expectations
        run_req(32'h10028, 256, 1'b0, 1'b0, 0);
        chk("R3", "example count", got_len.size(), 5);
        for (int i = 0; i < 5; i++)
            if (i < got_len.size()) chk("R3", "example chunk", got_len[i], want[i]);

        // R10 full-size request
        run_req(32'h20000, 4096, 1'b0, 1'b0, 3);
        chk("R10", "4096 count", got_len.size(), 64);

        // R6 zero length in both boundary settings
        run_req(32'h10010, 0, 1'b0, 1'b0, 0);
        run_req(32'h10010, 0, 1'b1, 1'b1, 2);

        for (int b = 0; b < 2; b++)
            for (int p = 0; p < 2; p++)
                for (int m = 0; m < 4; m++)
                    for (int o = 0; o < 8; o++)
                        for (int l = 0; l < 10; l++)
                            run_req(32'h10000 + offs[o], lens[l], b[0], p[0], m);

        summary();
        $finish;
    end

endmodule